// File: doc/BRIEF.md
# Prioritized Interrupt Wake-Up Qualifier

This block watches a set of interrupt request channels. It decides which pending requests may bring a processor, or a companion coprocessor, out of a low-power stop or wait state. While the processor is running, it also picks the single request that the processor should service next. Each channel carries a 3-bit priority level and a routing bit. The routing bit hands the channel either to the processor or to the coprocessor. Requests routed to the processor are checked against the processor's interrupt mask bit and its current priority level. These checks are the same whether the processor is running or asleep. Requests routed to the coprocessor never touch processor-side state.

The block keeps the processor's current priority level itself. When the processor accepts the offered request, the old level is pushed onto a small internal stack and the accepted request's level is loaded. A return pulse pops the previous level back. A dedicated non-maskable line wakes the processor from either low-power state at any time. In run mode the same line raises a separate service flag, which is gated by the non-maskable mask bit.

Top module: `irq_wake_qual`

## Requirements
- R1: While stop or wait is asserted, `cpu_wake_o` pulses high for exactly one cycle, in the cycle after the first clock edge at which a qualified processor request or the non-maskable line is present. The request must be removed and raised again to give another pulse. Both wake outputs stay low in run mode (stop = wait = 0).
- R2: While `i_mask_i` = 1, no maskable request raises `cpu_wake_o` or `svc_req_o`.
- R3: A processor-routed request whose level is less than or equal to `ipl_o` causes neither a wake-up nor a service request.
- R4: A request with `route_cop_i` bit = 1 never raises `cpu_wake_o` or `svc_req_o`, and never changes `ipl_o`.
- R5: While stop or wait is asserted, a pending coprocessor-routed request with a non-zero level gives a one-cycle `cop_wake_o` pulse, with the same timing as R1, whatever `i_mask_i` and `ipl_o` are.
- R6: The non-maskable line `nmi_i` gives a `cpu_wake_o` pulse in stop or wait mode even when `x_mask_i` = 1 and `i_mask_i` = 1.
- R7: A channel whose level is 0 never causes a wake-up or a service request.
- R8: `svc_idx_o` and `svc_lvl_o` name the qualified processor request with the highest level. On a tie, the lowest channel index wins.
- R9: An edge with `ack_i` = 1, `svc_req_o` = 1 and `rti_i` = 0 pushes `ipl_o` onto the stack and loads `svc_lvl_o` into `ipl_o` from the next cycle on. Otherwise `ipl_o` is unchanged, except through R10. After reset, `ipl_o` = 0.
- R10: An edge with `rti_i` = 1 pops the most recently pushed level into `ipl_o`. With an empty stack it leaves `ipl_o` unchanged. `rti_i` takes precedence, so a simultaneous `ack_i` is ignored.
- R11: A request held back by `ipl_o` stays pending. It is offered on `svc_req_o` in the first cycle after a return lowers `ipl_o` below its level.
- R12: `svc_req_o` is level-sensitive and combinational. It is asserted only in run mode.
- R13: In run mode, `nmi_svc_o` follows `nmi_i` while `x_mask_i` = 0. It is 0 while `x_mask_i` = 1, and 0 in stop or wait mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_CH | Pending request per channel |
| lvl_i | input | N_CH x 3 | Priority level per channel (0 = disabled) |
| route_cop_i | input | N_CH | 1 = channel belongs to the coprocessor |
| i_mask_i | input | 1 | Processor maskable-interrupt mask |
| x_mask_i | input | 1 | Non-maskable service mask |
| nmi_i | input | 1 | Non-maskable request line |
| stop_i | input | 1 | Stop mode flag |
| wait_i | input | 1 | Wait mode flag |
| ack_i | input | 1 | Processor accepts the offered request |
| rti_i | input | 1 | Return-from-interrupt pulse |
| cpu_wake_o | output | 1 | One-cycle processor wake strobe |
| cop_wake_o | output | 1 | One-cycle coprocessor wake strobe |
| svc_req_o | output | 1 | Processor service request (run mode) |
| svc_idx_o | output | clog2(N_CH) | Winning channel index |
| svc_lvl_o | output | 3 | Winning channel level |
| nmi_svc_o | output | 1 | Non-maskable service request (run mode) |
| ipl_o | output | 3 | Current processor priority level |

## Verification
The service outputs (`svc_req_o`, `svc_idx_o`, `svc_lvl_o`, `nmi_svc_o`) are combinational. They are due in the same cycle as the inputs and are sampled a settle delay after the drive. The wake strobes are registered and appear in the cycle after the clock edge that sees the condition. The bench therefore samples them just after that edge, and again one edge later to confirm that the pulse has ended. `ipl_o` follows one edge after an `ack_i` or `rti_i`. A request that was held back by the level is checked in that same post-edge cycle, which confirms it is released with no extra delay.

// File: rtl/irq_wq_pkg.sv
package irq_wq_pkg;

    localparam int LVL_W = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_WAIT = 2'd1,
        PM_STOP = 2'd2
    } pmode_t;

    // Per-channel classification produced by the qualifier stage.
    typedef struct packed {
        logic cpu_ok;   // maskable, processor-routed, passes mask and level checks
        logic cop_ok;   // coprocessor-routed, enabled and pending
    } chan_cls_t;

    // Stop dominates wait; either one is a low-power state.
    function automatic pmode_t decode_mode(input logic stop, input logic wt);
        if (stop)
            return PM_STOP;
        else if (wt)
            return PM_WAIT;
        return PM_RUN;
    endfunction

    // A level of zero marks a disabled channel.
    function automatic logic lvl_enabled(input lvl_t l);
        return l != '0;
    endfunction

    // The request must be strictly above the current level.
    function automatic logic lvl_above(input lvl_t req_l, input lvl_t cur_l);
        return req_l > cur_l;
    endfunction

endpackage

// File: rtl/irq_wq_qualify.sv
module irq_wq_qualify
    import irq_wq_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic [N_CH-1:0]            req_i,
    input  logic [N_CH-1:0][LVL_W-1:0] lvl_i,
    input  logic [N_CH-1:0]            route_cop_i,
    input  logic                       i_mask_i,
    input  lvl_t                       ipl_i,
    output chan_cls_t [N_CH-1:0]       cls_o
);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic live;
        assign live = req_i[g] && lvl_enabled(lvl_i[g]);

        always_comb begin
            cls_o[g].cpu_ok = live && !route_cop_i[g] && !i_mask_i
                              && lvl_above(lvl_i[g], ipl_i);
            cls_o[g].cop_ok = live && route_cop_i[g];
        end
    end

endmodule

// File: rtl/irq_wq_arbiter.sv
module irq_wq_arbiter
    import irq_wq_pkg::*;
#(
    parameter int N_CH  = 8,
    parameter int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0]            qual_i,
    input  logic [N_CH-1:0][LVL_W-1:0] lvl_i,
    output logic                       found_o,
    output logic [IDX_W-1:0]           idx_o,
    output lvl_t                       lvl_o
);

    // Scan from the top index down; ">=" lets a lower index take over a tie.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (qual_i[i] && (!found_o || lvl_i[i] >= lvl_o)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                lvl_o   = lvl_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_wq_ipl_stack.sv
module irq_wq_ipl_stack
    import irq_wq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push_i,
    input  logic pop_i,
    input  lvl_t new_lvl_i,
    output lvl_t ipl_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    lvl_t             mem [DEPTH];
    logic [CNT_W-1:0] sp;
    lvl_t             ipl_q;
    logic             empty;
    logic             full;
    logic [PTR_W-1:0] top_ptr;
    logic [PTR_W-1:0] wr_ptr;

    assign empty   = (sp == '0);
    assign full    = (sp == CNT_W'(DEPTH));
    assign top_ptr = PTR_W'(sp - 1'b1);
    assign wr_ptr  = PTR_W'(sp);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp    <= '0;
            ipl_q <= '0;
        end else if (pop_i) begin
            if (!empty) begin
                ipl_q <= mem[top_ptr];
                sp    <= sp - 1'b1;
            end
        end else if (push_i && !full) begin
            mem[wr_ptr] <= ipl_q;
            ipl_q       <= new_lvl_i;
            sp          <= sp + 1'b1;
        end
    end

    assign ipl_o = ipl_q;

endmodule

// File: rtl/irq_wq_wake_pulse.sv
module irq_wq_wake_pulse (
    input  logic clk,
    input  logic rst,
    input  logic cond_i,
    output logic pulse_o
);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 1'b0;
            pulse_o <= 1'b0;
        end else begin
            seen_q  <= cond_i;
            pulse_o <= cond_i && !seen_q;
        end
    end

endmodule

// File: rtl/irq_wake_qual.sv
module irq_wake_qual
    import irq_wq_pkg::*;
#(
    parameter int N_CH      = 8,
    parameter int STK_DEPTH = 8,
    parameter int IDX_W     = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_CH-1:0]            req_i,
    input  logic [N_CH-1:0][LVL_W-1:0] lvl_i,
    input  logic [N_CH-1:0]            route_cop_i,
    input  logic                       i_mask_i,
    input  logic                       x_mask_i,
    input  logic                       nmi_i,
    input  logic                       stop_i,
    input  logic                       wait_i,
    input  logic                       ack_i,
    input  logic                       rti_i,
    output logic                       cpu_wake_o,
    output logic                       cop_wake_o,
    output logic                       svc_req_o,
    output logic [IDX_W-1:0]           svc_idx_o,
    output logic [LVL_W-1:0]           svc_lvl_o,
    output logic                       nmi_svc_o,
    output logic [LVL_W-1:0]           ipl_o
);

    pmode_t               mode;
    logic                 in_run;
    logic                 low_pwr;
    lvl_t                 ipl;
    chan_cls_t [N_CH-1:0] cls;
    logic [N_CH-1:0]      cpu_ok;
    logic [N_CH-1:0]      cop_ok;
    logic                 win_found;
    logic [IDX_W-1:0]     win_idx;
    lvl_t                 win_lvl;
    logic                 cpu_wake_cond;
    logic                 cop_wake_cond;
    logic                 do_push;

    assign mode    = decode_mode(stop_i, wait_i);
    assign in_run  = (mode == PM_RUN);
    assign low_pwr = !in_run;

    irq_wq_qualify #(.N_CH(N_CH)) u_qual (
        .req_i       (req_i),
        .lvl_i       (lvl_i),
        .route_cop_i (route_cop_i),
        .i_mask_i    (i_mask_i),
        .ipl_i       (ipl),
        .cls_o       (cls)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_split
        assign cpu_ok[g] = cls[g].cpu_ok;
        assign cop_ok[g] = cls[g].cop_ok;
    end

    irq_wq_arbiter #(.N_CH(N_CH), .IDX_W(IDX_W)) u_arb (
        .qual_i  (cpu_ok),
        .lvl_i   (lvl_i),
        .found_o (win_found),
        .idx_o   (win_idx),
        .lvl_o   (win_lvl)
    );

    // Same qualification in sleep as in run; the non-maskable line ignores both masks.
    assign cpu_wake_cond = low_pwr && (nmi_i || (|cpu_ok));
    assign cop_wake_cond = low_pwr && (|cop_ok);

    irq_wq_wake_pulse u_cpu_wake (
        .clk     (clk),
        .rst     (rst),
        .cond_i  (cpu_wake_cond),
        .pulse_o (cpu_wake_o)
    );

    irq_wq_wake_pulse u_cop_wake (
        .clk     (clk),
        .rst     (rst),
        .cond_i  (cop_wake_cond),
        .pulse_o (cop_wake_o)
    );

    assign svc_req_o = in_run && win_found;
    assign svc_idx_o = win_idx;
    assign svc_lvl_o = win_lvl;
    assign nmi_svc_o = in_run && nmi_i && !x_mask_i;

    // A return in the same cycle wins over an acceptance.
    assign do_push = ack_i && svc_req_o && !rti_i;

    irq_wq_ipl_stack #(.DEPTH(STK_DEPTH)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push_i    (do_push),
        .pop_i     (rti_i),
        .new_lvl_i (win_lvl),
        .ipl_o     (ipl)
    );

    assign ipl_o = ipl;

endmodule

// File: rtl/irq_wq_checker.sv
module irq_wq_checker #(
    parameter int N_CH  = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [N_CH-1:0]  route_cop_i,
    input logic             i_mask_i,
    input logic             nmi_i,
    input logic             stop_i,
    input logic             wait_i,
    input logic             ack_i,
    input logic             rti_i,
    input logic             cpu_wake_o,
    input logic             cop_wake_o,
    input logic             svc_req_o,
    input logic [IDX_W-1:0] svc_idx_o,
    input logic [2:0]       svc_lvl_o,
    input logic [2:0]       ipl_o
);

    AST_WAKE_SLEEP_ONLY: assert property (@(posedge clk) disable iff (rst)
        cpu_wake_o |-> $past(stop_i || wait_i)); // R1
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cpu_wake_o |=> !cpu_wake_o); // R1
    AST_COP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        cop_wake_o |=> !cop_wake_o); // R5
    AST_NMI_WAKES: assert property (@(posedge clk) disable iff (rst)
        ($rose(stop_i || wait_i) && nmi_i) |=> cpu_wake_o); // R6
    AST_MASK_BLOCKS_SVC: assert property (@(posedge clk) disable iff (rst)
        svc_req_o |-> !i_mask_i); // R2
    AST_SVC_ABOVE_IPL: assert property (@(posedge clk) disable iff (rst)
        svc_req_o |-> (svc_lvl_o > ipl_o)); // R3
    AST_SVC_NOT_COP: assert property (@(posedge clk) disable iff (rst)
        svc_req_o |-> !route_cop_i[svc_idx_o]); // R4
    AST_SVC_LVL_NONZERO: assert property (@(posedge clk) disable iff (rst)
        svc_req_o |-> (svc_lvl_o != 3'd0)); // R7
    AST_ACK_LOADS: assert property (@(posedge clk) disable iff (rst)
        (ack_i && svc_req_o && !rti_i) |=> (ipl_o == $past(svc_lvl_o))); // R9
    AST_IPL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ack_i && !rti_i) |=> $stable(ipl_o)); // R9
    AST_SVC_RUN_ONLY: assert property (@(posedge clk) disable iff (rst)
        (stop_i || wait_i) |-> !svc_req_o); // R12

endmodule

bind irq_wake_qual irq_wq_checker #(.N_CH(N_CH), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/irq_wake_qual_bench.sv
module irq_wake_qual_bench;

    localparam int N     = 8;
    localparam int IDX_W = 3;

    logic               clk = 1'b0;
    logic               rst;
    logic [N-1:0]       req;
    logic [N-1:0][2:0]  lvl;
    logic [N-1:0]       route;
    logic               imask, xmask, nmi, stop, wt, ack, rti;
    logic               cpu_wake, cop_wake, svc_req, nmi_svc;
    logic [IDX_W-1:0]   svc_idx;
    logic [2:0]         svc_lvl, ipl;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    irq_wake_qual #(.N_CH(N), .STK_DEPTH(8)) u_irq_wake_qual (
        .clk(clk), .rst(rst), .req_i(req), .lvl_i(lvl), .route_cop_i(route),
        .i_mask_i(imask), .x_mask_i(xmask), .nmi_i(nmi), .stop_i(stop),
        .wait_i(wt), .ack_i(ack), .rti_i(rti), .cpu_wake_o(cpu_wake),
        .cop_wake_o(cop_wake), .svc_req_o(svc_req), .svc_idx_o(svc_idx),
        .svc_lvl_o(svc_lvl), .nmi_svc_o(nmi_svc), .ipl_o(ipl)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic clear_in();
        req = '0; lvl = '0; route = '0;
        imask = 0; xmask = 0; nmi = 0; stop = 0; wt = 0; ack = 0; rti = 0;
    endtask

    task automatic do_ack();
        ack = 1; tick(); ack = 0; settle();
    endtask

    task automatic do_rti();
        rti = 1; tick(); rti = 0; settle();
    endtask

    task automatic t_reset();
        chk("R9", "ipl after reset", ipl, 0);
        chk("R12", "svc_req after reset", svc_req, 0);
        chk("R1", "cpu_wake after reset", cpu_wake, 0);
        chk("R5", "cop_wake after reset", cop_wake, 0);
    endtask

    task automatic t_arbitration();
        req[2] = 1; lvl[2] = 3'd4;
        req[5] = 1; lvl[5] = 3'd6;
        req[6] = 1; lvl[6] = 3'd6;
        settle();
        chk("R8", "svc_req", svc_req, 1);
        chk("R8", "tie idx", svc_idx, 5);
        chk("R8", "tie lvl", svc_lvl, 6);
        req[1] = 1; lvl[1] = 3'd7; settle();
        chk("R8", "highest idx", svc_idx, 1);
        chk("R8", "highest lvl", svc_lvl, 7);
        req = '0; lvl = '0; settle();
    endtask

    task automatic t_level_zero();
        req[4] = 1; lvl[4] = 3'd0; settle();
        chk("R7", "svc_req lvl0", svc_req, 0);
        stop = 1; tick();
        chk("R7", "cpu_wake lvl0", cpu_wake, 0);
        route[4] = 1; tick();
        chk("R7", "cop_wake lvl0", cop_wake, 0);
        clear_in(); tick();
    endtask

    task automatic t_imask();
        imask = 1; req[3] = 1; lvl[3] = 3'd5; settle();
        chk("R2", "svc_req masked", svc_req, 0);
        stop = 1; tick();
        chk("R2", "cpu_wake masked", cpu_wake, 0);
        tick();
        chk("R2", "cpu_wake masked later", cpu_wake, 0);
        clear_in(); tick();
    endtask

    task automatic t_cpu_wake();
        stop = 1; tick();
        chk("R1", "no wake without request", cpu_wake, 0);
        req[2] = 1; lvl[2] = 3'd3; tick();
        chk("R1", "stop wake pulse", cpu_wake, 1);
        chk("R12", "svc_req in stop", svc_req, 0);
        tick();
        chk("R1", "pulse ends", cpu_wake, 0);
        req = '0; stop = 0; wt = 1; tick();
        req[2] = 1; tick();
        chk("R1", "wait wake pulse", cpu_wake, 1);
        chk("R12", "svc_req in wait", svc_req, 0);
        wt = 0; settle();
        chk("R12", "svc_req back in run", svc_req, 1);
        tick();
        chk("R1", "no wake in run", cpu_wake, 0);
        clear_in(); tick();
    endtask

    task automatic t_ipl_block();
        req[0] = 1; lvl[0] = 3'd5; settle();
        do_ack();
        chk("R9", "ipl loaded", ipl, 5);
        chk("R3", "equal level no svc", svc_req, 0);
        stop = 1; tick();
        chk("R3", "equal level no wake", cpu_wake, 0);
        tick();
        chk("R3", "equal level no wake 2", cpu_wake, 0);
        req[1] = 1; lvl[1] = 3'd6; tick();
        chk("R3", "higher level wakes", cpu_wake, 1);
        req = '0; lvl = '0; stop = 0; settle();
        do_rti();
        chk("R10", "ipl popped", ipl, 0);
    endtask

    task automatic t_release();
        req[3] = 1; lvl[3] = 3'd5; settle();
        do_ack();
        req[3] = 0; req[4] = 1; lvl[4] = 3'd4; settle();
        chk("R11", "blocked while ipl 5", svc_req, 0);
        rti = 1; tick(); rti = 0;
        chk("R11", "released svc_req", svc_req, 1);
        chk("R11", "released idx", svc_idx, 4);
        chk("R11", "released lvl", svc_lvl, 4);
        clear_in(); settle();
    endtask

    task automatic t_nesting();
        do_rti();
        chk("R10", "rti on empty stack", ipl, 0);
        req[0] = 1; lvl[0] = 3'd2; settle(); do_ack();
        chk("R9", "first push", ipl, 2);
        req[0] = 0; req[1] = 1; lvl[1] = 3'd5; settle(); do_ack();
        chk("R9", "second push", ipl, 5);
        req = '0; settle();
        do_rti();
        chk("R10", "pop to 2", ipl, 2);
        do_rti();
        chk("R10", "pop to 0", ipl, 0);
        req[2] = 1; lvl[2] = 3'd3; settle();
        ack = 1; rti = 1; tick(); ack = 0; rti = 0; settle();
        chk("R10", "rti beats ack", ipl, 0);
        clear_in(); settle();
    endtask

    task automatic t_coproc();
        req[5] = 1; lvl[5] = 3'd4; route[5] = 1; imask = 1; stop = 1; tick();
        chk("R5", "cop wake despite mask", cop_wake, 1);
        chk("R4", "no cpu wake for cop req", cpu_wake, 0);
        tick();
        chk("R5", "cop pulse ends", cop_wake, 0);
        stop = 0; imask = 0; settle();
        chk("R4", "no svc for cop req", svc_req, 0);
        do_ack();
        chk("R4", "ipl untouched", ipl, 0);
        req[6] = 1; lvl[6] = 3'd7; settle(); do_ack();
        req[6] = 0; req[5] = 0; settle();
        wt = 1; tick();
        req[5] = 1; tick();
        chk("R5", "cop wake despite ipl 7", cop_wake, 1);
        clear_in(); settle();
        do_rti();
        chk("R10", "ipl restored", ipl, 0);
    endtask

    task automatic t_nmi();
        xmask = 1; imask = 1; nmi = 1; stop = 1; tick();
        chk("R6", "nmi wake with X set", cpu_wake, 1);
        chk("R13", "nmi_svc in stop", nmi_svc, 0);
        stop = 0; settle();
        chk("R13", "nmi_svc masked by X", nmi_svc, 0);
        xmask = 0; settle();
        chk("R13", "nmi_svc run", nmi_svc, 1);
        tick();
        chk("R1", "nmi no wake in run", cpu_wake, 0);
        clear_in(); tick();
    endtask

    initial begin
        clear_in();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        settle();
        t_reset();
        t_arbitration();
        t_level_zero();
        t_imask();
        t_cpu_wake();
        t_ipl_block();
        t_release();
        t_nesting();
        t_coproc();
        t_nmi();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule